// File: doc/BRIEF.md
# Timed-Access Write Guard for Control Registers

This block stands between a processor's register write bus and a small set of critical control registers. It stops stray code from changing their sensitive bits. To change a guarded bit, software first writes a two-byte key to a dedicated unlock address: AAh, then 55h. That opens a short window of three machine cycles. During the window, one write to a guarded register may change its protected bits.

For every write on the bus, the block drives a per-bit write-enable vector, and the register file applies it bit by bit. Bits that a guarded register does not protect always follow the write. Protected bits follow it only while the window is open. Outside the window, a write to a protected bit is dropped without any error indication.

The write strobe, qualified by the machine-cycle enable, acts as the valid of the incoming write stream. The block never applies back-pressure: every strobed write is consumed in the same cycle, so there is no ready signal.

Top module: `ta_write_guard`

## Requirements
- R1: After reset the window is closed, and a write to a guarded register enables only that register's unprotected bits.
- R2: A write of AAh to address C7h, followed by a write of 55h to C7h as the next write, opens the window from the following cycle; `win_open` goes to 1.
- R3: The window stays open for exactly three machine cycles. Cycles with `mc_en` low do not count, and nothing changes state in them.
- R4: A write to a guarded register inside the window drives `wr_bit_en` to FFh and pulses `prot_accept`.
- R5: Once a guarded write has been accepted, the window closes on the next cycle, so one unlock allows a single protected write.
- R6: Outside the window, `wr_bit_en` is the inverse of the register's protection mask. The masks are: D8h → 4Bh (bits 6, 3, 1, 0), 9Dh → 3Fh, D7h → 7Fh, 91h → 01h.
- R7: A write to any address that is not guarded drives `wr_bit_en` to FFh, whether the window is open or closed.
- R8: If the write after AAh is not 55h to C7h, the key sequencer returns to idle. A later lone 55h then opens nothing.
- R9: A write to any other address between the two key writes cancels the sequence.
- R10: In a cycle without a strobed write (`sfr_we` low or `mc_en` low), `wr_bit_en` is 00h and the key sequencer does not advance.
- R11: `guard_hit` is 1 during a strobed write to one of the four guarded addresses and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_en | input | 1 | Machine-cycle enable; qualifies writes and window counting |
| sfr_we | input | 1 | Write strobe of the register bus |
| sfr_addr | input | 8 | Register address of the write |
| sfr_wdata | input | 8 | Write data |
| wr_bit_en | output | 8 | Per-bit write enable for the current write |
| guard_hit | output | 1 | Current write targets a guarded register |
| prot_accept | output | 1 | Guarded write accepted inside the window |
| win_open | output | 1 | Access window is open |

## Verification
The assertions assume that the address and data carry meaning only in cycles where `sfr_we` and `mc_en` are both high. They also assume that the inputs settle between clock edges, so each strobed write is seen exactly once at a rising edge. The stimulus changes every input just after the falling edge, holds it through the next rising edge, and checks the combinational outputs before that edge. Machine-cycle gaps are produced by driving `mc_en` low for whole clock cycles, never by gating the strobe in the middle of a cycle.

// File: rtl/ta_guard_pkg.sv
package ta_guard_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HALF = 1'b1
  } seq_state_e;

  localparam int GUARD_CNT = 4;

  // entry 0 in the low byte
  localparam logic [GUARD_CNT*8-1:0] GUARD_ADDRS = {8'h91, 8'hD7, 8'h9D, 8'hD8};
  localparam logic [GUARD_CNT*8-1:0] GUARD_MASKS = {8'h01, 8'h7F, 8'h3F, 8'h4B};

endpackage

// File: rtl/ta_key_seq.sv
module ta_key_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              half,
  output logic              arm
);
  import ta_guard_pkg::*;

  seq_state_e state_q, state_d;
  logic       key_sel;

  assign key_sel = (addr == KEY_ADDR);

  always_comb begin
    state_d = state_q;
    arm     = 1'b0;
    if (wr_strobe) begin
      unique case (state_q)
        SEQ_IDLE: if (key_sel && wdata == KEY_FIRST) state_d = SEQ_HALF;
        SEQ_HALF: begin
          state_d = SEQ_IDLE;
          if (key_sel && wdata == KEY_SECOND) arm = 1'b1;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign half = (state_q == SEQ_HALF);

endmodule

// File: rtl/ta_window.sv
module ta_window #(
  parameter int WIN_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_en,
  input  logic arm,
  input  logic accept,
  output logic open
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (mc_en) begin
      if (arm)               cnt_q <= CNT_W'(WIN_CYCLES);
      else if (accept)       cnt_q <= '0;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open = (cnt_q != '0);

endmodule

// File: rtl/ta_mask_lut.sv
module ta_mask_lut #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_GUARDED = 4,
  parameter logic [NUM_GUARDED*ADDR_W-1:0] GUARD_ADDRS = '0,
  parameter logic [NUM_GUARDED*DATA_W-1:0] GUARD_MASKS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [DATA_W-1:0] mask
);
  logic [NUM_GUARDED-1:0] sel;

  for (genvar g = 0; g < NUM_GUARDED; g++) begin : g_cmp
    assign sel[g] = (addr == GUARD_ADDRS[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < NUM_GUARDED; i++) begin
      if (sel[i]) mask = mask | GUARD_MASKS[i*DATA_W +: DATA_W];
    end
  end

  assign hit = |sel;

endmodule

// File: rtl/ta_write_guard.sv
module ta_write_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WIN_CYCLES = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter int NUM_GUARDED = ta_guard_pkg::GUARD_CNT,
  parameter logic [NUM_GUARDED*ADDR_W-1:0] GUARD_ADDRS = ta_guard_pkg::GUARD_ADDRS,
  parameter logic [NUM_GUARDED*DATA_W-1:0] GUARD_MASKS = ta_guard_pkg::GUARD_MASKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] wr_bit_en,
  output logic              guard_hit,
  output logic              prot_accept,
  output logic              win_open
);
  logic              wr_strobe;
  logic              key_half;
  logic              arm_pulse;
  logic              addr_hit;
  logic [DATA_W-1:0] prot_mask;

  assign wr_strobe = mc_en & sfr_we;

  ta_key_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe),
    .addr(sfr_addr), .wdata(sfr_wdata), .half(key_half), .arm(arm_pulse)
  );

  ta_mask_lut #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GUARDED(NUM_GUARDED),
    .GUARD_ADDRS(GUARD_ADDRS), .GUARD_MASKS(GUARD_MASKS)
  ) u_lut (
    .addr(sfr_addr), .hit(addr_hit), .mask(prot_mask)
  );

  ta_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en),
    .arm(arm_pulse), .accept(prot_accept), .open(win_open)
  );

  assign guard_hit   = wr_strobe & addr_hit;
  assign prot_accept = guard_hit & win_open;

  always_comb begin
    if (!wr_strobe)                wr_bit_en = '0;
    else if (addr_hit && !win_open) wr_bit_en = ~prot_mask;
    else                           wr_bit_en = '1;
  end

endmodule

// File: rtl/ta_write_guard_chk.sv
module ta_write_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WIN_CYCLES = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mc_en,
  input logic              sfr_we,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [DATA_W-1:0] wr_bit_en,
  input logic              guard_hit,
  input logic              prot_accept,
  input logic              win_open,
  input logic              key_half,
  input logic              arm_pulse,
  input logic [DATA_W-1:0] prot_mask
);
  logic        strobe;
  logic [31:0] open_run;

  assign strobe = mc_en & sfr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      open_run <= '0;
    else if (!win_open || arm_pulse) open_run <= '0;
    else if (mc_en)                  open_run <= open_run + 32'd1;
  end

  p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && key_half && sfr_addr == KEY_ADDR && sfr_wdata == KEY_SECOND) |=> win_open);

  p_win_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    open_run <= 32'(WIN_CYCLES));

  p_hold_no_mc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_en |=> ($stable(win_open) && $stable(key_half)));

  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_accept |=> !win_open);

  p_closed_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_hit && !win_open) |-> ((wr_bit_en & prot_mask) == '0));

  p_unguarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !guard_hit) |-> (wr_bit_en == '1));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (wr_bit_en == '0 && !guard_hit && !prot_accept));

endmodule

bind ta_write_guard ta_write_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_CYCLES(WIN_CYCLES),
  .KEY_ADDR(KEY_ADDR), .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .sfr_we(sfr_we),
  .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .wr_bit_en(wr_bit_en),
  .guard_hit(guard_hit), .prot_accept(prot_accept), .win_open(win_open),
  .key_half(key_half), .arm_pulse(arm_pulse), .prot_mask(prot_mask)
);

// File: tb/ta_write_guard_tb.sv
module ta_write_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_en = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] wr_bit_en;
  logic       guard_hit, prot_accept, win_open;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ta_write_guard u_dut (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .wr_bit_en(wr_bit_en),
    .guard_hit(guard_hit), .prot_accept(prot_accept), .win_open(win_open)
  );

  function automatic logic [7:0] exp_mask(input logic [7:0] a);
    case (a)
      8'hD8:   return 8'h4B;
      8'h9D:   return 8'h3F;
      8'hD7:   return 8'h7F;
      8'h91:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock cycle: inputs set after falling edge, outputs readable on return
  task automatic cyc(input logic mc, input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    mc_en = mc; sfr_we = we; sfr_addr = a; sfr_wdata = d;
    #1;
  endtask

  task automatic idle();
    cyc(1'b1, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic unlock();
    cyc(1'b1, 1'b1, 8'hC7, 8'hAA);
    cyc(1'b1, 1'b1, 8'hC7, 8'h55);
  endtask

  task automatic t_reset();
    cyc(1'b0, 1'b0, 8'h00, 8'h00);
    chk("R1 win_open after reset", {7'd0, win_open}, 8'h00);
    cyc(1'b1, 1'b1, 8'hD8, 8'hFF);
    chk("R1 bit_en after reset", wr_bit_en, 8'hB4);
  endtask

  task automatic t_window_len();
    unlock();
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R2/R3 window open", {7'd0, win_open}, 8'h01);
    end
    idle();
    chk("R3 window closed after three", {7'd0, win_open}, 8'h00);
  endtask

  task automatic t_single_write();
    unlock();
    idle();
    cyc(1'b1, 1'b1, 8'h9D, 8'h12);
    chk("R4 bit_en inside window", wr_bit_en, 8'hFF);
    chk("R4 prot_accept", {7'd0, prot_accept}, 8'h01);
    cyc(1'b1, 1'b1, 8'h9D, 8'h34);
    chk("R5 window closed after accept", {7'd0, win_open}, 8'h00);
    chk("R5 second write masked", wr_bit_en, 8'hC0);
    chk("R5 no second accept", {7'd0, prot_accept}, 8'h00);
  endtask

  task automatic t_last_cycle();
    unlock();
    idle(); idle();
    cyc(1'b1, 1'b1, 8'h91, 8'h01);
    chk("R4 write in third window cycle", wr_bit_en, 8'hFF);
    idle();
    chk("R5 closed after last-cycle write", {7'd0, win_open}, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] al [4] = '{8'hD8, 8'h9D, 8'hD7, 8'h91};
    foreach (al[k]) begin
      cyc(1'b1, 1'b1, al[k], 8'hA5);
      chk("R6 closed mask", wr_bit_en, ~exp_mask(al[k]));
      chk("R11 guard_hit set", {7'd0, guard_hit}, 8'h01);
    end
  endtask

  task automatic t_unguarded();
    cyc(1'b1, 1'b1, 8'h80, 8'h3C);
    chk("R7 unguarded closed", wr_bit_en, 8'hFF);
    chk("R11 guard_hit clear", {7'd0, guard_hit}, 8'h00);
    unlock();
    cyc(1'b1, 1'b1, 8'hD9, 8'h00);
    chk("R7 unguarded open", wr_bit_en, 8'hFF);
    chk("R7 window survives unguarded write", {7'd0, win_open}, 8'h01);
    idle(); idle(); idle();
  endtask

  task automatic t_bad_second();
    cyc(1'b1, 1'b1, 8'hC7, 8'hAA);
    cyc(1'b1, 1'b1, 8'hC7, 8'h56);
    cyc(1'b1, 1'b1, 8'hC7, 8'h55);
    idle();
    chk("R8 wrong second byte", {7'd0, win_open}, 8'h00);
  endtask

  task automatic t_interloper();
    cyc(1'b1, 1'b1, 8'hC7, 8'hAA);
    cyc(1'b1, 1'b1, 8'h90, 8'h00);
    cyc(1'b1, 1'b1, 8'hC7, 8'h55);
    idle();
    chk("R9 foreign write cancels key", {7'd0, win_open}, 8'h00);
    cyc(1'b1, 1'b1, 8'hD7, 8'hFF);
    chk("R9 still masked", wr_bit_en, 8'h80);
  endtask

  task automatic t_no_strobe();
    cyc(1'b0, 1'b1, 8'hD8, 8'hFF);
    chk("R10 mc_en low bit_en", wr_bit_en, 8'h00);
    chk("R11 guard_hit without strobe", {7'd0, guard_hit}, 8'h00);
    cyc(1'b1, 1'b0, 8'hD8, 8'hFF);
    chk("R10 we low bit_en", wr_bit_en, 8'h00);
    cyc(1'b1, 1'b1, 8'hC7, 8'hAA);
    cyc(1'b0, 1'b1, 8'h90, 8'h00);
    cyc(1'b1, 1'b1, 8'hC7, 8'h55);
    idle();
    chk("R10 unqualified write ignored by sequencer", {7'd0, win_open}, 8'h01);
    idle(); idle(); idle();
  endtask

  task automatic t_slow_mc();
    unlock();
    for (int i = 0; i < 6; i++) begin
      cyc(i % 2 == 1, 1'b0, 8'h00, 8'h00);
      chk("R3 window counts machine cycles", {7'd0, win_open}, 8'h01);
    end
    cyc(1'b0, 1'b0, 8'h00, 8'h00);
    chk("R3 closed after three machine cycles", {7'd0, win_open}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window_len();
    t_single_write();
    t_last_cycle();
    t_masks();
    t_unguarded();
    t_bad_second();
    t_interloper();
    t_no_strobe();
    t_slow_mc();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule